// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs management transactions toward an Ethernet PHY over a two-wire serial management link. It drives a management clock (`mdc`) and a shared data line. The data line is modelled as three signals: a data output, an output enable and a data input. A host issues one request at a time. The request gives the operation (register read, register write or presence probe), a 5-bit register number and, for writes, 16 bits of data. The block serialises the frame and generates every clock pulse. For a read, it also checks that the PHY answers and captures the returned word. When it finishes, it raises a one-cycle completion pulse.

Each bit period has two halves. The clock is low for the first half and high for the second, and each half lasts `HALF_CYCLES` system clocks. The master changes its output data only while the clock is low. Input data is sampled at the edge where the clock falls. The line has a pull-up, so a released line reads high.

An absent PHY is detected in one of two ways. During a read, the line still reads high at the end of the turnaround slot. In probe mode, the line is released for 32 pulses and then sampled. A high level on that sample means a device is present.

Top module: `mdioMaster`

## Requirements
- R1: A read or write starts with 32 bit periods in which the output is enabled and the data output is 1.
- R2: The 16-bit command word is sent MSB first, with these fields: [15:14]=01 (start), [13:12]=10 for a read or 01 for a write, [11:7]=`PHY_ADDR`, [6:2]=register number, [1:0]=10 on a write (unused on a read).
- R3: On a read, the master drives only command bits 15..2 (14 periods). It releases the line from the next period until the end of the transaction.
- R4: On a read, the line is sampled at the end of the single released turnaround period. If it reads 1, the transaction ends with `done` and `noResp`=1. No further clock pulses follow (47 pulses in total), and `rdData` keeps its previous value.
- R5: After a valid turnaround, 16 released periods follow. The line is sampled as `mdc` falls in each period, and the bits are assembled MSB first. At `done`, `rdData` holds the word and `noResp`=0.
- R6: A write drives 32 bits MSB first: first the command word (with turnaround 10), then the write data.
- R7: After a completed read or write, 2 more clock pulses are issued with the line released. A full read is therefore 65 pulses and a write is 66 pulses.
- R8: The clock high and low halves each last exactly `HALF_CYCLES` system clocks. The data output and the output enable stay constant while `mdc` is high.
- R9: A probe issues 32 pulses with the line released and then samples the line. `noResp` is set to the inverse of the sampled level. A probe has no preamble and no trailing clocks.
- R10: `busy` is high from the cycle after a request is accepted until `done`. A request is accepted only when `reqValid` is high and `busy` is low. A request made while busy has no effect.
- R11: During and just after reset, `mdc`, `mdoEn`, `busy` and `done` are low.
- R12: `done` is high for exactly one cycle, and `busy` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqOp | input | 2 | Operation: 0 read, 1 write, 2 probe |
| reqReg | input | 5 | PHY register number |
| reqWrData | input | 16 | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| noResp | output | 1 | No PHY answer (read) or no PHY found (probe); valid at `done`, held until the next completion |
| rdData | output | 16 | Last successfully read register value |
| mdc | output | 1 | Management clock to the PHY |
| mdo | output | 1 | Data line output value |
| mdoEn | output | 1 | Data line output enable |
| mdi | input | 1 | Data line input level |

## Verification
A PHY model in the bench records the output enable and data level at every rising `mdc` and answers reads with random words. It also covers absent devices: a stuck-high line for reads and a low line for probes. A frame that is one bit too long or too short shows up as a wrong pulse count and a shifted command word. A master that kept driving through the turnaround would show `mdoEn` high at pulse 46. A master that ignored an absent PHY would report a bogus `rdData` and would keep clocking past 47 pulses. Requests injected mid-transaction must leave the frame untouched, so a design that restarted or queued them would change the pulse counts or leave `busy` high after `done`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int WORD_BITS = 16;
  localparam int ADDR_BITS = 5;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_PROBE = 2'd2
  } mdioOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch a new frame
    logic shiftOut;  // advance transmit shifter
    logic shiftIn;   // shift a sampled bit in
    logic commit;    // last read bit: publish the word
  } dpStrobe_t;
endpackage

// File: rtl/mdioCtrl.sv
module mdioCtrl
  import mdio_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int PRE_BITS    = 32,
  parameter int TRAIL_BITS  = 2,
  parameter int RD_CMD_BITS = 14
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic [1:0] reqOp,
  input  logic      mdi,
  output logic      busy,
  output logic      done,
  output logic      noResp,
  output logic      mdc,
  output logic      oe,
  output logic      drivePre,
  output dpStrobe_t stb
);
  localparam int TW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int MAXB = (PRE_BITS > WORD_BITS) ? PRE_BITS : WORD_BITS;
  localparam int CW = $clog2(MAXB);
  localparam logic [TW-1:0] T_LOAD   = TW'(HALF_CYCLES - 1);
  localparam logic [CW-1:0] C_PRE    = CW'(PRE_BITS - 1);
  localparam logic [CW-1:0] C_RDCMD  = CW'(RD_CMD_BITS - 1);
  localparam logic [CW-1:0] C_WORD   = CW'(WORD_BITS - 1);
  localparam logic [CW-1:0] C_TRAIL  = CW'(TRAIL_BITS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_CMD, S_TA, S_DATA, S_TRAIL, S_PROBE
  } state_e;

  state_e  state;
  mdioOp_e op;
  logic [TW-1:0] timer;
  logic [CW-1:0] bitCnt;
  logic phaseHigh;
  logic slotEnd;
  logic lastBit;

  assign slotEnd = (state != S_IDLE) && phaseHigh && (timer == '0);
  assign lastBit = (bitCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      op        <= OP_READ;
      timer     <= '0;
      bitCnt    <= '0;
      phaseHigh <= 1'b0;
      done      <= 1'b0;
      noResp    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (reqValid) begin
          op        <= mdioOp_e'(reqOp);
          state     <= (mdioOp_e'(reqOp) == OP_PROBE) ? S_PROBE : S_PRE;
          bitCnt    <= C_PRE;
          timer     <= T_LOAD;
          phaseHigh <= 1'b0;
        end
      end else if (timer != '0) begin
        timer <= timer - 1'b1;
      end else if (!phaseHigh) begin
        phaseHigh <= 1'b1;
        timer     <= T_LOAD;
      end else begin
        phaseHigh <= 1'b0;
        timer     <= T_LOAD;
        bitCnt    <= bitCnt - 1'b1;
        case (state)
          S_PRE: if (lastBit) begin
            state  <= S_CMD;
            bitCnt <= (op == OP_READ) ? C_RDCMD : C_WORD;
          end
          S_CMD: if (lastBit) begin
            state  <= (op == OP_READ) ? S_TA : S_DATA;
            bitCnt <= C_WORD;
          end
          S_TA: begin
            if (mdi) begin
              state  <= S_IDLE;
              done   <= 1'b1;
              noResp <= 1'b1;
            end else begin
              state  <= S_DATA;
              bitCnt <= C_WORD;
            end
          end
          S_DATA: if (lastBit) begin
            state  <= S_TRAIL;
            bitCnt <= C_TRAIL;
          end
          S_TRAIL: if (lastBit) begin
            state  <= S_IDLE;
            done   <= 1'b1;
            noResp <= 1'b0;
          end
          S_PROBE: if (lastBit) begin
            state  <= S_IDLE;
            done   <= 1'b1;
            noResp <= !mdi;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign busy     = (state != S_IDLE);
  assign mdc      = phaseHigh;
  assign drivePre = (state == S_PRE);
  assign oe       = (state == S_PRE) || (state == S_CMD) ||
                    ((state == S_DATA) && (op == OP_WRITE));

  always_comb begin
    stb          = '0;
    stb.load     = (state == S_IDLE) && reqValid;
    stb.shiftOut = slotEnd && ((state == S_CMD) ||
                   ((state == S_DATA) && (op == OP_WRITE)));
    stb.shiftIn  = slotEnd && (state == S_DATA) && (op == OP_READ);
    stb.commit   = stb.shiftIn && lastBit;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !oe)); // R11
  AST_NORESP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(noResp)); // R4
endmodule

// File: rtl/mdioDatapath.sv
module mdioDatapath
  import mdio_pkg::*;
#(
  parameter logic [ADDR_BITS-1:0] PHY_ADDR = 5'h01
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            stb,
  input  logic [1:0]           reqOp,
  input  logic [ADDR_BITS-1:0] reqReg,
  input  logic [WORD_BITS-1:0] reqWrData,
  input  logic                 mdi,
  input  logic                 drivePre,
  input  logic                 oe,
  output logic                 mdo,
  output logic [WORD_BITS-1:0] rdData
);
  localparam int TX_BITS = 2 * WORD_BITS;

  logic [TX_BITS-1:0]   txShift;
  logic [WORD_BITS-1:0] rxShift;

  function automatic logic [WORD_BITS-1:0] buildCmd(
      input mdioOp_e o, input logic [ADDR_BITS-1:0] r);
    logic [1:0] opc;
    logic [1:0] tail;
    opc  = (o == OP_WRITE) ? 2'b01 : 2'b10;
    tail = (o == OP_WRITE) ? 2'b10 : 2'b00;
    return {2'b01, opc, PHY_ADDR, r, tail};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rdData  <= '0;
    end else begin
      if (stb.load)
        txShift <= {buildCmd(mdioOp_e'(reqOp), reqReg), reqWrData};
      else if (stb.shiftOut)
        txShift <= {txShift[TX_BITS-2:0], 1'b0};
      if (stb.shiftIn)
        rxShift <= {rxShift[WORD_BITS-2:0], mdi};
      if (stb.commit)
        rdData <= {rxShift[WORD_BITS-2:0], mdi};
    end
  end

  assign mdo = oe && (drivePre || txShift[TX_BITS-1]);
endmodule

// File: rtl/mdioMaster.sv
module mdioMaster
  import mdio_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter logic [4:0] PHY_ADDR = 5'h01
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [4:0]  reqReg,
  input  logic [15:0] reqWrData,
  output logic        busy,
  output logic        done,
  output logic        noResp,
  output logic [15:0] rdData,
  output logic        mdc,
  output logic        mdo,
  output logic        mdoEn,
  input  logic        mdi
);
  dpStrobe_t stb;
  logic drivePre;

  mdioCtrl #(.HALF_CYCLES(HALF_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .mdi(mdi),
    .busy(busy), .done(done), .noResp(noResp), .mdc(mdc), .oe(mdoEn),
    .drivePre(drivePre), .stb(stb)
  );

  mdioDatapath #(.PHY_ADDR(PHY_ADDR)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqOp(reqOp), .reqReg(reqReg),
    .reqWrData(reqWrData), .mdi(mdi), .drivePre(drivePre), .oe(mdoEn),
    .mdo(mdo), .rdData(rdData)
  );

  AST_MDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> ($stable(mdo) && $stable(mdoEn))); // R8
endmodule

// File: tb/sim_mdioMaster.sv
module sim_mdioMaster;
  localparam int HALF = 3;
  localparam logic [4:0] PADDR = 5'h0B;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [4:0] reqReg = '0;
  logic [15:0] reqWrData = '0;
  logic busy, done, noResp, mdc, mdo, mdoEn;
  logic [15:0] rdData;
  logic mdi = 1'b1;

  int checks = 0;
  int fails = 0;
  int timingErr = 0;

  always #2 clk = ~clk;

  mdioMaster #(.HALF_CYCLES(HALF), .PHY_ADDR(PADDR)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqReg(reqReg), .reqWrData(reqWrData), .busy(busy), .done(done),
    .noResp(noResp), .rdData(rdData), .mdc(mdc), .mdo(mdo), .mdoEn(mdoEn),
    .mdi(mdi)
  );

  // PHY model
  int edgeIdx = 0;
  bit modelRead = 0;
  bit modelPresent = 0;
  logic [15:0] phyData = '0;
  logic recOe [0:79];
  logic recMdo [0:79];

  always @(posedge mdc) begin
    if (edgeIdx < 80) begin
      recOe[edgeIdx]  = mdoEn;
      recMdo[edgeIdx] = mdo;
    end
    if (modelRead) begin
      if (modelPresent && edgeIdx == 46) mdi <= 1'b0;
      else if (modelPresent && edgeIdx >= 47 && edgeIdx <= 62) mdi <= phyData[62 - edgeIdx];
      else mdi <= 1'b1;
    end
    edgeIdx = edgeIdx + 1;
  end

  // half-period and stability monitor (R8)
  logic prevMdc = 1'b0, prevMdo = 1'b0, prevOe = 1'b0;
  int lowCnt = 0, highCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (mdc && prevMdc && (mdo != prevMdo || mdoEn != prevOe)) timingErr++;
      if (mdc) begin
        if (!prevMdc) begin
          if (lowCnt != HALF) timingErr++;
          highCnt = 0;
        end
        highCnt++;
        lowCnt = 0;
      end else begin
        if (prevMdc && highCnt != HALF) timingErr++;
        if (busy) lowCnt++; else lowCnt = 0;
      end
    end
    prevMdc = mdc; prevMdo = mdo; prevOe = mdoEn;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expCmd(input int op, input logic [4:0] r);
    logic [1:0] opc;
    logic [1:0] tl;
    opc = (op == 1) ? 2'b01 : 2'b10;
    tl  = (op == 1) ? 2'b10 : 2'b00;
    return {2'b01, opc, PADDR, r, tl};
  endfunction

  function automatic int expEdges(input int op, input bit present);
    if (op == 2) return 32;
    if (op == 1) return 66;
    return present ? 65 : 47;
  endfunction

  task automatic runTxn(input int op, input logic [4:0] r, input logic [15:0] d,
                        input bit present, input bit inject);
    logic [15:0] oldRd;
    logic [15:0] cmd;
    logic [31:0] wr;
    int waited;
    bit preOk, cmdOk, relOk;
    oldRd = rdData;
    cmd = expCmd(op, r);
    wr = {cmd, d};
    @(negedge clk);
    edgeIdx = 0;
    modelRead = (op == 0);
    modelPresent = present;
    phyData = $urandom();
    mdi = (op == 2) ? present : 1'b1;
    reqValid = 1'b1; reqOp = op[1:0]; reqReg = r; reqWrData = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy, "R10", "busy after accept", busy, 1);
    waited = 0;
    while (!done && waited < 3000) begin
      if (inject && waited == 20) begin
        reqValid = 1'b1; reqOp = 2'd2; reqReg = ~r; reqWrData = ~d;
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    reqValid = 1'b0;
    check(done, "R12", "done seen", done, 1);
    check(!busy, "R12", "busy low at done", busy, 0);
    check(edgeIdx == expEdges(op, present), (op == 2) ? "R9" : (op == 1 || present) ? "R7" : "R4",
          "mdc pulse count", edgeIdx, expEdges(op, present));
    preOk = 1; cmdOk = 1; relOk = 1;
    if (op == 2) begin
      for (int i = 0; i < 32; i++) if (recOe[i]) relOk = 0;
      check(relOk, "R9", "probe line released", relOk, 1);
      check(noResp == !present, "R9", "probe result", noResp, !present);
    end else begin
      for (int i = 0; i < 32; i++) if (!recOe[i] || !recMdo[i]) preOk = 0;
      check(preOk, "R1", "preamble ones", preOk, 1);
      if (op == 1) begin
        for (int i = 0; i < 32; i++) if (!recOe[32+i] || recMdo[32+i] != wr[31-i]) cmdOk = 0;
        check(cmdOk, "R6", "write frame bits", cmdOk, 1);
        check(!recOe[64] && !recOe[65], "R7", "write trailing release", recOe[64], 0);
        check(!noResp, "R6", "write noResp", noResp, 0);
      end else begin
        for (int i = 0; i < 14; i++) if (!recOe[32+i] || recMdo[32+i] != cmd[15-i]) cmdOk = 0;
        check(cmdOk, "R2", "read command bits", cmdOk, 1);
        for (int i = 46; i < expEdges(0, present); i++) if (recOe[i]) relOk = 0;
        check(relOk, "R3", "read line released", relOk, 1);
        if (present) begin
          check(!noResp, "R5", "read noResp", noResp, 0);
          check(rdData == phyData, "R5", "read data", rdData, phyData);
        end else begin
          check(noResp, "R4", "absent noResp", noResp, 1);
          check(rdData == oldRd, "R4", "rdData kept", rdData, oldRd);
        end
      end
    end
    @(negedge clk);
    check(!done, "R12", "done one cycle", done, 0);
    check(!busy, "R10", "no late start", busy, 0);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!mdc && !mdoEn && !busy && !done, "R11", "reset outputs",
          {mdc, mdoEn, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!mdc && !mdoEn && !busy && !done, "R11", "post-reset outputs",
          {mdc, mdoEn, busy, done}, 0);
    // directed corners
    runTxn(0, 5'h1F, 16'h0000, 1, 0);   // R2 R5 all-ones register
    runTxn(0, 5'h00, 16'h0000, 0, 0);   // R4 absent PHY
    runTxn(1, 5'h15, 16'hA5C3, 1, 0);   // R6 write
    runTxn(2, 5'h00, 16'h0000, 1, 0);   // R9 present
    runTxn(2, 5'h00, 16'h0000, 0, 0);   // R9 absent
    runTxn(0, 5'h0A, 16'h0000, 1, 1);   // R10 ignored request
    runTxn(1, 5'h03, 16'hFFFF, 1, 1);   // R10 ignored request on write
    // random mix
    for (int n = 0; n < 30; n++) begin
      int op;
      op = $urandom_range(0, 2);
      runTxn(op, 5'($urandom()), 16'($urandom()), 1'($urandom_range(0, 3) != 0),
             1'($urandom_range(0, 1)));
    end
    check(timingErr == 0, "R8", "half periods and stability", timingErr, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule